// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit system control registers on a simple word-addressed bus. A bus cycle is one clock with `bus_valid` high. `bus_write` picks a store or a load, and `bus_addr` is a byte address. Only aligned full-word accesses take effect. Load data is registered and appears on `bus_rdata` after the clock edge that ends the load cycle.

The bank holds these registers:
- An unlock key word. Software proves its intent by writing a fixed constant there.
- Four reset and clock-gate control words. Each has a set port and a companion clear port one word above it.
- Two strap words, loaded from input pins at reset. Each strap word can be frozen against setting through a protect word two words above it.
- Fixed revision and identification words.
- A PLL configuration word, and three PLL extension words that always report lock.
- A random data word, whose value is taken from an input port at the moment it is read.

A store attempted while the bank is locked still takes effect. In that case the bank also raises a one-cycle warning pulse that an interrupt or trace block can collect.

Top module: `ctl_regbank`

## Requirements
- R1: The word index is `bus_addr >> 2`. An access whose `bus_addr[1:0]` is nonzero is dropped: a store changes nothing, and a load returns 0.
- R2: An access whose word index is `NUM_WORDS` (default 1024, a 4 KiB region) or more is dropped. Such a load returns 0 and such a store changes no register. Addresses do not alias onto lower words.
- R3: A store to byte offset 0x000 sets the key state to 1 when the data equals `UNLOCK_KEY`, and to 0 for any other data. A load there returns the key state in bit 0 with the other bits zero. At reset the key state takes the value of `key_init`.
- R4: The control words at 0x040, 0x050, 0x080 and 0x090 reset to 0xF7C3FED8, 0xFFFFFFFC, 0xFFFF7F8A and 0xFFF0FFF0. A store to one of them ORs the store data into it.
- R5: A store to 0x044, 0x054, 0x084 or 0x094 clears, in the control word one word below, every bit that is 1 in the store data. These clear ports read as 0.
- R6: The strap words at 0x500 and 0x510 reset from `strap_a_init` and `strap_b_init`, and a store to them ORs the data in. Such a store is ignored while the protect word two words above (0x508 or 0x518) is nonzero. The protect words are plain read/write and reset to 0. The clear ports at 0x504 and 0x514 clear strap bits whether or not the protect word is set.
- R7: The following words ignore stores:
  - 0x004 reads `REV_PRIMARY`;
  - 0x014 reads `REV_SECONDARY`;
  - 0x5B0 reads `CHIP_ID_LO` (default 0x1234ABCD);
  - 0x5B4 reads `CHIP_ID_HI` (default 0x88884444);
  - 0x540 is the random data word, and stores to it are ignored as well.
- R8: The PLL configuration word at 0x200 is plain read/write and resets to 0x1000405F. The PLL extension words at 0x204, 0x224 and 0x244 are plain storage that resets to 0, but a load from them returns the stored value with bit 31 forced to 1.
- R9: A load from 0x540 returns the value that `rng_in` carries in the cycle of the load.
- R10: `locked_write_err` is high for exactly the one cycle after an aligned, in-range store to any word other than 0x000 made while the key state is 0. The store is still performed.
- R11: `bus_rdata` resets to 0, is loaded only by a load cycle and holds its value otherwise. In-range aligned words that are not implemented read as 0 and ignore stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Registered load data |
| rng_in | input | 32 | Random word from an external source |
| strap_a_init | input | 32 | Reset value of strap word A |
| strap_b_init | input | 32 | Reset value of strap word B |
| key_init | input | 1 | Reset value of the key state |
| locked_write_err | output | 1 | One-cycle pulse after a locked store |

## Verification
The bench works through the following corner cases, and each one exposes a specific fault:
- **Misaligned and out-of-region stores to a live control word.** A decoder that drops the low address bits, or that truncates the word index, would corrupt that word.
- **A strap store under protection, followed by a strap clear.** A bank that gates the clear port as well, or that forgets the protect gate, would leave a wrong strap value.
- **PLL extension reads.** A bank that stores the forced lock bit instead of overlaying it would read back wrong.
- **Two random reads with different input values.** These expose a stale latch.
- **A locked store, observed before and after the pulse.** A design that suppresses the locked store, stretches the pulse, or flags stores to the key word would fail this check.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  localparam int DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;

  // Word indices (byte offset >> 2)
  localparam int IDX_KEY     = 32'h000;
  localparam int IDX_REV_A   = 32'h001;
  localparam int IDX_REV_B   = 32'h005;
  localparam int IDX_PLL_CFG = 32'h080;
  localparam int IDX_RNG     = 32'h150;
  localparam int IDX_ID_LO   = 32'h16C;
  localparam int IDX_ID_HI   = 32'h16D;

  // Set/clear control words; clear port sits CLR_STEP words above
  localparam int SC_N = 4;
  localparam int SC_IDX [SC_N] = '{32'h010, 32'h014, 32'h020, 32'h024};
  localparam int CLR_STEP = 1;

  // Strap words; protect word sits PROT_STEP words above
  localparam int STRAP_N = 2;
  localparam int STRAP_IDX [STRAP_N] = '{32'h140, 32'h144};
  localparam int PROT_STEP = 2;

  // PLL extension words
  localparam int PLLX_N = 3;
  localparam int PLLX_IDX [PLLX_N] = '{32'h081, 32'h089, 32'h091};
  localparam int LOCK_BIT = 31;

  localparam int MAX_WORDS = 1024;

  function automatic logic key_state(input word_t data, input word_t key);
    return (data == key);
  endfunction

  function automatic word_t set_bits(input word_t cur, input word_t data);
    return cur | data;
  endfunction

  function automatic word_t clear_bits(input word_t cur, input word_t data);
    return cur & ~data;
  endfunction

  function automatic word_t pll_view(input word_t stored);
    return stored | (word_t'(1) << LOCK_BIT);
  endfunction

endpackage

// File: rtl/ctl_regbank_decode.sv
module ctl_regbank_decode
  import ctl_regbank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_WORDS = 1024
)(
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic              rd_req,
  output logic [31:0]       word_idx
);
  localparam int IDX_BITS = ADDR_W - 2;

  logic aligned;
  logic in_range;

  always_comb begin
    aligned  = (bus_addr[1:0] == 2'b00);
    word_idx = 32'(bus_addr[ADDR_W-1:2]);
    in_range = (word_idx < 32'(NUM_WORDS));
    rd_req   = bus_valid && !bus_write;
    acc_rd   = rd_req && aligned && in_range;
    acc_wr   = bus_valid && bus_write && aligned && in_range;
  end

endmodule

// File: rtl/ctl_regbank_setclr.sv
module ctl_regbank_setclr
  import ctl_regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t init_val,
  input  logic  set_en,
  input  logic  clr_en,
  input  logic  set_block,
  input  word_t wdata,
  output word_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= init_val;
    end else if (set_en && !set_block) begin
      q <= set_bits(q, wdata);
    end else if (clr_en) begin
      q <= clear_bits(q, wdata);
    end
  end

endmodule

// File: rtl/ctl_regbank_rdmux.sv
module ctl_regbank_rdmux
  import ctl_regbank_pkg::*;
#(
  parameter word_t REV_PRIMARY   = 32'h0600_0301,
  parameter word_t REV_SECONDARY = 32'h0600_0302,
  parameter word_t CHIP_ID_LO    = 32'h1234_ABCD,
  parameter word_t CHIP_ID_HI    = 32'h8888_4444
)(
  input  logic [31:0]                   word_idx,
  input  logic                          key_q,
  input  logic [SC_N-1:0][DATA_W-1:0]    sc_q,
  input  logic [STRAP_N-1:0][DATA_W-1:0] strap_q,
  input  logic [STRAP_N-1:0][DATA_W-1:0] prot_q,
  input  word_t                         pll_cfg_q,
  input  logic [PLLX_N-1:0][DATA_W-1:0]  pllx_q,
  input  word_t                         rng_in,
  output word_t                         rd_value
);

  always_comb begin
    rd_value = '0;
    if (word_idx == IDX_KEY)     rd_value = word_t'(key_q);
    if (word_idx == IDX_REV_A)   rd_value = REV_PRIMARY;
    if (word_idx == IDX_REV_B)   rd_value = REV_SECONDARY;
    if (word_idx == IDX_ID_LO)   rd_value = CHIP_ID_LO;
    if (word_idx == IDX_ID_HI)   rd_value = CHIP_ID_HI;
    if (word_idx == IDX_RNG)     rd_value = rng_in;
    if (word_idx == IDX_PLL_CFG) rd_value = pll_cfg_q;
    for (int k = 0; k < SC_N; k++) begin
      if (word_idx == SC_IDX[k]) rd_value = sc_q[k];
    end
    for (int k = 0; k < STRAP_N; k++) begin
      if (word_idx == STRAP_IDX[k])             rd_value = strap_q[k];
      if (word_idx == STRAP_IDX[k] + PROT_STEP) rd_value = prot_q[k];
    end
    for (int k = 0; k < PLLX_N; k++) begin
      if (word_idx == PLLX_IDX[k]) rd_value = pll_view(pllx_q[k]);
    end
  end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int    ADDR_W        = 16,
  parameter int    NUM_WORDS     = 1024,
  parameter word_t UNLOCK_KEY    = 32'h1688_A8A8,
  parameter word_t REV_PRIMARY   = 32'h0600_0301,
  parameter word_t REV_SECONDARY = 32'h0600_0302,
  parameter word_t CHIP_ID_LO    = 32'h1234_ABCD,
  parameter word_t CHIP_ID_HI    = 32'h8888_4444,
  parameter word_t PLL_CFG_RESET = 32'h1000_405F,
  parameter logic [SC_N-1:0][DATA_W-1:0] SC_RESET =
    {32'hFFF0_FFF0, 32'hFFFF_7F8A, 32'hFFFF_FFFC, 32'hF7C3_FED8}
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       rng_in,
  input  logic [31:0]       strap_a_init,
  input  logic [31:0]       strap_b_init,
  input  logic              key_init,
  output logic              locked_write_err
);

  // Decoded bus events (named for the checker)
  logic        acc_wr;
  logic        acc_rd;
  logic        rd_req;
  logic [31:0] word_idx;

  ctl_regbank_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .rd_req    (rd_req),
    .word_idx  (word_idx)
  );

  // R3: key state
  logic key_q;
  logic key_wr_hit;
  assign key_wr_hit = acc_wr && (word_idx == IDX_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n)          key_q <= key_init;
    else if (key_wr_hit) key_q <= key_state(bus_wdata, UNLOCK_KEY);
  end

  // R4/R5: set/clear control words
  logic [SC_N-1:0][DATA_W-1:0] sc_q;

  for (genvar g = 0; g < SC_N; g++) begin : g_sc
    logic set_hit;
    logic clr_hit;
    assign set_hit = acc_wr && (word_idx == SC_IDX[g]);
    assign clr_hit = acc_wr && (word_idx == SC_IDX[g] + CLR_STEP);
    ctl_regbank_setclr u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_val  (SC_RESET[g]),
      .set_en    (set_hit),
      .clr_en    (clr_hit),
      .set_block (1'b0),
      .wdata     (bus_wdata),
      .q         (sc_q[g])
    );
  end

  // R6: strap words with protect words
  logic [STRAP_N-1:0][DATA_W-1:0] strap_init;
  logic [STRAP_N-1:0][DATA_W-1:0] strap_q;
  logic [STRAP_N-1:0][DATA_W-1:0] prot_q;
  logic [STRAP_N-1:0]             strap_frozen;

  assign strap_init = {strap_b_init, strap_a_init};

  for (genvar g = 0; g < STRAP_N; g++) begin : g_strap
    logic set_hit;
    logic clr_hit;
    logic prot_hit;
    assign set_hit         = acc_wr && (word_idx == STRAP_IDX[g]);
    assign clr_hit         = acc_wr && (word_idx == STRAP_IDX[g] + CLR_STEP);
    assign prot_hit        = acc_wr && (word_idx == STRAP_IDX[g] + PROT_STEP);
    assign strap_frozen[g] = |prot_q[g];

    ctl_regbank_setclr u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_val  (strap_init[g]),
      .set_en    (set_hit),
      .clr_en    (clr_hit),
      .set_block (strap_frozen[g]),
      .wdata     (bus_wdata),
      .q         (strap_q[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        prot_q[g] <= '0;
      else if (prot_hit) prot_q[g] <= bus_wdata;
    end
  end

  // R8: PLL configuration and extension words
  word_t                        pll_cfg_q;
  logic [PLLX_N-1:0][DATA_W-1:0] pllx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    pll_cfg_q <= PLL_CFG_RESET;
    else if (acc_wr && (word_idx == IDX_PLL_CFG)) pll_cfg_q <= bus_wdata;
  end

  for (genvar g = 0; g < PLLX_N; g++) begin : g_pllx
    always_ff @(posedge clk) begin
      if (!rst_n)                                    pllx_q[g] <= '0;
      else if (acc_wr && (word_idx == PLLX_IDX[g])) pllx_q[g] <= bus_wdata;
    end
  end

  // R10: locked store warning
  logic locked_attempt;
  assign locked_attempt = acc_wr && (word_idx != IDX_KEY) && !key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) locked_write_err <= 1'b0;
    else        locked_write_err <= locked_attempt;
  end

  // R7/R9/R11: read path
  word_t rd_value;

  ctl_regbank_rdmux #(
    .REV_PRIMARY   (REV_PRIMARY),
    .REV_SECONDARY (REV_SECONDARY),
    .CHIP_ID_LO    (CHIP_ID_LO),
    .CHIP_ID_HI    (CHIP_ID_HI)
  ) u_rdmux (
    .word_idx  (word_idx),
    .key_q     (key_q),
    .sc_q      (sc_q),
    .strap_q   (strap_q),
    .prot_q    (prot_q),
    .pll_cfg_q (pll_cfg_q),
    .pllx_q    (pllx_q),
    .rng_in    (rng_in),
    .rd_value  (rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= acc_rd ? rd_value : '0;
  end

endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
#(
  parameter int    ADDR_W     = 16,
  parameter int    NUM_WORDS  = 1024,
  parameter word_t UNLOCK_KEY = 32'h1688_A8A8
)(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic                          key_q,
  input logic                          acc_rd,
  input logic [31:0]                   word_idx,
  input logic [STRAP_N-1:0][DATA_W-1:0] strap_q,
  input logic [STRAP_N-1:0][DATA_W-1:0] prot_q,
  input logic                          locked_write_err
);

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == '0) |=> (key_q == ($past(bus_wdata) == UNLOCK_KEY))); // R3

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (32'(bus_addr[ADDR_W-1:2]) >= 32'(NUM_WORDS))) |=> (bus_rdata == '0)); // R2

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0)); // R1

  AST_PLL_LOCK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (word_idx == PLLX_IDX[0] || word_idx == PLLX_IDX[1] || word_idx == PLLX_IDX[2]))
      |=> bus_rdata[LOCK_BIT]); // R8

  AST_STRAP_A_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && word_idx == STRAP_IDX[0] && prot_q[0] != '0) |=> $stable(strap_q[0])); // R6

  AST_STRAP_B_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && word_idx == STRAP_IDX[1] && prot_q[1] != '0) |=> $stable(strap_q[1])); // R6

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_write_err |-> $past(bus_valid && bus_write && !key_q)); // R10

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R11

endmodule

bind ctl_regbank ctl_regbank_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_WORDS  (NUM_WORDS),
  .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_valid        (bus_valid),
  .bus_write        (bus_write),
  .bus_addr         (bus_addr),
  .bus_wdata        (bus_wdata),
  .bus_rdata        (bus_rdata),
  .key_q            (key_q),
  .acc_rd           (acc_rd),
  .word_idx         (word_idx),
  .strap_q          (strap_q),
  .prot_q           (prot_q),
  .locked_write_err (locked_write_err)
);

// File: tb/ctl_regbank_tb_top.sv
module ctl_regbank_tb_top;

  localparam logic [31:0] KEY   = 32'h1688_A8A8;
  localparam logic [31:0] REV_A = 32'h0600_0301;
  localparam logic [31:0] REV_B = 32'h0600_0302;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] rng_in = '0;
  logic [31:0] strap_a_init = 32'h0000_00F0;
  logic [31:0] strap_b_init = 32'h0000_0001;
  logic        key_init = 1'b1;
  logic        locked_write_err;

  int checks = 0;
  int errors = 0;
  int err_pulses = 0;

  always #2 clk = ~clk;

  ctl_regbank dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_valid        (bus_valid),
    .bus_write        (bus_write),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .rng_in           (rng_in),
    .strap_a_init     (strap_a_init),
    .strap_b_init     (strap_b_init),
    .key_init         (key_init),
    .locked_write_err (locked_write_err)
  );

  // Vector: {req[3:0], write, addr[15:0], data[31:0]}; for reads data is expected
  localparam int NV = 60;
  localparam logic [52:0] VEC [NV] = '{
    {4'd3,  1'b0, 16'h0000, 32'h0000_0001}, // R3 key_init state
    {4'd4,  1'b0, 16'h0040, 32'hF7C3_FED8}, // R4
    {4'd4,  1'b1, 16'h0040, 32'h0000_0027}, // R4
    {4'd4,  1'b0, 16'h0040, 32'hF7C3_FEFF}, // R4
    {4'd5,  1'b1, 16'h0044, 32'hF000_0000}, // R5
    {4'd5,  1'b0, 16'h0040, 32'h07C3_FEFF}, // R5
    {4'd5,  1'b0, 16'h0044, 32'h0000_0000}, // R5
    {4'd4,  1'b0, 16'h0050, 32'hFFFF_FFFC}, // R4
    {4'd5,  1'b1, 16'h0054, 32'h0000_FFFF}, // R5
    {4'd4,  1'b1, 16'h0050, 32'h0000_0003}, // R4
    {4'd5,  1'b0, 16'h0050, 32'hFFFF_0003}, // R5
    {4'd4,  1'b0, 16'h0080, 32'hFFFF_7F8A}, // R4
    {4'd5,  1'b1, 16'h0084, 32'hFFFF_FFFF}, // R5
    {4'd5,  1'b0, 16'h0080, 32'h0000_0000}, // R5
    {4'd4,  1'b0, 16'h0090, 32'hFFF0_FFF0}, // R4
    {4'd4,  1'b1, 16'h0090, 32'h000F_0000}, // R4
    {4'd4,  1'b0, 16'h0090, 32'hFFFF_FFF0}, // R4
    {4'd6,  1'b0, 16'h0500, 32'h0000_00F0}, // R6
    {4'd6,  1'b1, 16'h0500, 32'h0000_000F}, // R6
    {4'd6,  1'b0, 16'h0500, 32'h0000_00FF}, // R6
    {4'd6,  1'b1, 16'h0504, 32'h0000_0030}, // R6
    {4'd6,  1'b0, 16'h0500, 32'h0000_00CF}, // R6
    {4'd6,  1'b1, 16'h0508, 32'h0000_0001}, // R6
    {4'd6,  1'b0, 16'h0508, 32'h0000_0001}, // R6
    {4'd6,  1'b1, 16'h0500, 32'h0000_0100}, // R6 frozen
    {4'd6,  1'b0, 16'h0500, 32'h0000_00CF}, // R6
    {4'd6,  1'b1, 16'h0504, 32'h0000_000F}, // R6 clear not gated
    {4'd6,  1'b0, 16'h0500, 32'h0000_00C0}, // R6
    {4'd6,  1'b0, 16'h0510, 32'h0000_0001}, // R6
    {4'd6,  1'b1, 16'h0510, 32'h0000_0080}, // R6
    {4'd6,  1'b0, 16'h0510, 32'h0000_0081}, // R6
    {4'd7,  1'b1, 16'h0004, 32'hFFFF_FFFF}, // R7
    {4'd7,  1'b0, 16'h0004, REV_A},         // R7
    {4'd7,  1'b1, 16'h0014, 32'h0000_0000}, // R7
    {4'd7,  1'b0, 16'h0014, REV_B},         // R7
    {4'd7,  1'b1, 16'h05B0, 32'h0000_0000}, // R7
    {4'd7,  1'b0, 16'h05B0, 32'h1234_ABCD}, // R7
    {4'd7,  1'b1, 16'h05B4, 32'hFFFF_FFFF}, // R7
    {4'd7,  1'b0, 16'h05B4, 32'h8888_4444}, // R7
    {4'd8,  1'b0, 16'h0200, 32'h1000_405F}, // R8
    {4'd8,  1'b1, 16'h0200, 32'h1234_5678}, // R8
    {4'd8,  1'b0, 16'h0200, 32'h1234_5678}, // R8
    {4'd8,  1'b0, 16'h0204, 32'h8000_0000}, // R8
    {4'd8,  1'b1, 16'h0204, 32'h0000_0055}, // R8
    {4'd8,  1'b0, 16'h0204, 32'h8000_0055}, // R8
    {4'd8,  1'b1, 16'h0224, 32'h8000_0001}, // R8
    {4'd8,  1'b0, 16'h0224, 32'h8000_0001}, // R8
    {4'd8,  1'b0, 16'h0244, 32'h8000_0000}, // R8
    {4'd11, 1'b1, 16'h0100, 32'hDEAD_BEEF}, // R11
    {4'd11, 1'b0, 16'h0100, 32'h0000_0000}, // R11
    {4'd2,  1'b1, 16'h1040, 32'hFFFF_FFFF}, // R2 no alias onto 0x040
    {4'd2,  1'b0, 16'h0040, 32'h07C3_FEFF}, // R2
    {4'd2,  1'b0, 16'h1040, 32'h0000_0000}, // R2
    {4'd1,  1'b1, 16'h0042, 32'hFFFF_FFFF}, // R1
    {4'd1,  1'b0, 16'h0040, 32'h07C3_FEFF}, // R1
    {4'd1,  1'b0, 16'h0042, 32'h0000_0000}, // R1
    {4'd3,  1'b1, 16'h0000, 32'h1234_5678}, // R3
    {4'd3,  1'b0, 16'h0000, 32'h0000_0000}, // R3
    {4'd3,  1'b1, 16'h0000, KEY},           // R3
    {4'd3,  1'b0, 16'h0000, 32'h0000_0001}  // R3
  };

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(negedge clk) if (rst_n && locked_write_err) err_pulses++;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    apply_reset();
    @(negedge clk);
    check(11, bus_rdata, 32'h0);                      // R11 reset value
    check(10, 32'(locked_write_err), 32'h0);          // R10 idle after reset

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) begin
        do_write(VEC[i][47:32], VEC[i][31:0]);
      end else begin
        do_read(VEC[i][47:32], rd);
        check(int'(VEC[i][52:49]), rd, VEC[i][31:0]);
      end
    end
    check(10, 32'(err_pulses), 32'h0);                // R10 no pulse while unlocked

    // R9: fresh random value on each read
    rng_in = 32'hA5A5_0001;
    do_read(16'h0540, rd);
    check(9, rd, 32'hA5A5_0001);                      // R9
    rng_in = 32'h5A5A_0002;
    do_read(16'h0540, rd);
    check(9, rd, 32'h5A5A_0002);                      // R9
    rng_in = 32'h0BAD_0BAD;
    repeat (2) @(negedge clk);
    check(11, bus_rdata, 32'h5A5A_0002);              // R11 holds while idle

    // Second reset: locked, new straps
    key_init = 1'b0;
    strap_a_init = 32'h0000_0011;
    strap_b_init = 32'h0000_0022;
    apply_reset();
    @(negedge clk);
    check(11, bus_rdata, 32'h0);                      // R11
    do_read(16'h0000, rd); check(3, rd, 32'h0);       // R3 key_init low
    do_read(16'h0500, rd); check(6, rd, 32'h11);      // R6 strap reset
    do_read(16'h0510, rd); check(6, rd, 32'h22);      // R6
    do_read(16'h0040, rd); check(4, rd, 32'hF7C3_FED8); // R4 reset restored

    // R10: locked store pulses once and still lands
    do_write(16'h0090, 32'h0000_000F);
    check(10, 32'(locked_write_err), 32'h1);          // R10 pulse
    @(negedge clk);
    check(10, 32'(locked_write_err), 32'h0);          // R10 single cycle
    do_read(16'h0090, rd); check(10, rd, 32'hFFF0_FFFF); // R10 store performed
    do_write(16'h1000, 32'h1);
    check(10, 32'(locked_write_err), 32'h0);          // R10 out of range no pulse
    do_write(16'h0000, KEY);
    check(10, 32'(locked_write_err), 32'h0);          // R10 key store no pulse
    do_write(16'h0090, 32'h0);
    check(10, 32'(locked_write_err), 32'h0);          // R10 unlocked no pulse

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule